// File: doc/BRIEF.md
# Ethernet Collision Backoff Timer

This block sets the random wait that a half-duplex Ethernet transmitter observes after a collision. When the collision pulse arrives and no wait is already running, the block reads the retry count of the frame and a free-running 20-bit pseudo-random register. It keeps only the low bits of that register that the retry count and a 2-bit limit setting allow, and the result is the number of slot-times to wait. Each slot-time is 512 bit times, counted on a bit-time tick supplied by the transmitter.

While the wait runs, the block holds a busy flag. When the remaining count reaches zero it raises a one-cycle completion pulse and then drops busy. The limit setting can reduce the number of random bits below what the retry count alone would allow. This shortens the worst-case wait and makes the station retry more aggressively than the standard truncated exponential rule. Counting retries, sending the jam pattern and sensing the carrier are handled outside this block.

Top module: `collision_backoff_timer`

## Requirements
- R1: Synchronous active-low reset clears busy_o and done_o to 0 and loads the random register with the seed 20'h5A5A5.
- R2: The random register is 20 bits wide and advances on every clock out of reset. It shifts one place toward the MSB, and its new bit 0 is old bit 19 XOR old bit 16 (taps 20 and 17). It is never zero.
- R3: A clock edge with collision_i high and busy_o low samples the wait w. w is the value of the random register at that edge ANDed with a mask of its low E bits. busy_o is high from the next cycle.
- R4: E is the smallest of three values: retry_cnt_i, 10, and the limit width. limit_sel_i maps 2'b00 to 10 bits, 2'b01 to 8, 2'b10 to 4 and 2'b11 to 1.
- R5: While busy, every 512th bit_tick_i lowers the remaining wait by one slot. When the remaining wait is zero, done_o is high for exactly one cycle and busy_o is low in the following cycle. With bit_tick_i held high, done_o appears in the cycle that starts w*512 edges after the sampling edge.
- R6: When the sampled wait is 0, done_o is high in the cycle right after the sampling edge.
- R7: collision_i while busy_o is high, including the done_o cycle, is ignored. The running wait and its completion time do not change, and no new wait starts afterwards.
- R8: A retry count of 0 gives E = 0, so the wait is zero regardless of the random register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| collision_i | input | 1 | Collision pulse that requests a new backoff |
| retry_cnt_i | input | 5 | Retry count of the current frame |
| limit_sel_i | input | 2 | Backoff limit setting |
| bit_tick_i | input | 1 | One pulse per bit time |
| busy_o | output | 1 | A backoff wait is in progress |
| done_o | output | 1 | One-cycle pulse when the wait has elapsed |

## Verification
Two events can fall in the same cycle: a collision arriving while the completion pulse is being raised, and the start of a new wait. The bench drives a collision in exactly the cycle where a zero-length wait signals completion. It also drives one in the middle of a long wait. A behavioural model that knows the polynomial and the seed predicts busy and done on every clock. Both outputs must match the model, and both must show that no second wait was started. The bench also waits for random values that set bits above the allowed width. It then checks the measured wait length, which shows whether the mask took the smaller of the retry exponent and the limit width.

// File: rtl/backoff_pkg.sv
// Shared types and constants for the collision backoff timer.
// Assumes the limit encodings below are fixed by the transmit control logic.
package backoff_pkg;

    // Encoding of the backoff-limit setting
    typedef enum logic [1:0] {
        LIM_WIDE   = 2'b00,
        LIM_MEDIUM = 2'b01,
        LIM_NARROW = 2'b10,
        LIM_SINGLE = 2'b11
    } limit_e;

    // Number of random bits allowed by each limit setting
    localparam int LIM_WIDE_BITS   = 10;
    localparam int LIM_MEDIUM_BITS = 8;
    localparam int LIM_NARROW_BITS = 4;
    localparam int LIM_SINGLE_BITS = 1;

endpackage

// File: rtl/backoff_lfsr.sv
// Free-running Fibonacci LFSR used as the backoff random source.
// Assumes SEED is nonzero and the taps form a maximal-length polynomial.
module backoff_lfsr #(
    parameter int             W     = 20,
    parameter int             TAP_A = 20,
    parameter int             TAP_B = 17,
    parameter logic [W-1:0]   SEED  = 20'h5A5A5
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] lfsr_o
);

    logic [W-1:0] lfsr_q;
    logic         fb;

    // Feedback bit from the two taps
    assign fb = lfsr_q[TAP_A-1] ^ lfsr_q[TAP_B-1];

    // Shift toward the MSB every clock, reload seed on reset
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= {lfsr_q[W-2:0], fb};
    end

    assign lfsr_o = lfsr_q;

endmodule

// File: rtl/backoff_exp_mask.sv
// Builds the mask of random bits that set the backoff wait.
// The width is min(retry, MAX_EXP, limit width). Assumes MAX_EXP >= 10.
module backoff_exp_mask
    import backoff_pkg::*;
#(
    parameter int RETRY_W = 5,
    parameter int MAX_EXP = 10
) (
    input  logic [RETRY_W-1:0] retry_i,
    input  limit_e             limit_i,
    output logic [MAX_EXP-1:0] mask_o
);

    localparam int EXP_W = $clog2(MAX_EXP + 1);

    logic [EXP_W-1:0] k_exp;
    logic [EXP_W-1:0] lim_bits;
    logic [EXP_W-1:0] eff_bits;

    // Truncate the retry count at the exponent ceiling
    always_comb begin
        if (retry_i > RETRY_W'(MAX_EXP)) k_exp = EXP_W'(MAX_EXP);
        else                             k_exp = EXP_W'(retry_i);
    end

    // Translate the limit setting into a bit count
    always_comb begin
        unique case (limit_i)
            LIM_WIDE:   lim_bits = EXP_W'(LIM_WIDE_BITS);
            LIM_MEDIUM: lim_bits = EXP_W'(LIM_MEDIUM_BITS);
            LIM_NARROW: lim_bits = EXP_W'(LIM_NARROW_BITS);
            default:    lim_bits = EXP_W'(LIM_SINGLE_BITS);
        endcase
    end

    // The effective width is the smaller of the two
    always_comb begin
        eff_bits = (k_exp < lim_bits) ? k_exp : lim_bits;
    end

    // One mask bit per position: set below the effective width
    genvar gi;
    generate
        for (gi = 0; gi < MAX_EXP; gi++) begin : g_mask
            assign mask_o[gi] = (EXP_W'(gi) < eff_bits);
        end
    endgenerate

endmodule

// File: rtl/backoff_slot_timer.sv
// Counts a loaded number of slot-times down on bit ticks.
// It pulses done when the count reaches zero and ignores start while busy.
// Assumes tick_i is a single-cycle strobe per bit time.
module backoff_slot_timer #(
    parameter int SLOT_BITS = 512,
    parameter int CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             tick_i,
    output logic             busy_o,
    output logic             done_o
);

    localparam int               SLOT_W    = $clog2(SLOT_BITS);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_BITS - 1);

    logic              busy_q;
    logic [CNT_W-1:0]  rem_q;
    logic [SLOT_W-1:0] slot_q;
    logic              rem_zero;

    assign rem_zero = (rem_q == '0);

    // Load on start when idle, then count bit ticks and slots down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            slot_q <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                rem_q  <= load_i;
                slot_q <= '0;
            end
        end else if (rem_zero) begin
            busy_q <= 1'b0;
        end else if (tick_i) begin
            if (slot_q == SLOT_LAST) begin
                slot_q <= '0;
                rem_q  <= rem_q - 1'b1;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = busy_q && rem_zero;

endmodule

// File: rtl/collision_backoff_timer.sv
// Top level of the half-duplex transmit backoff engine.
// It samples a masked random wait on a collision and times it in slot-times.
// Assumes retry counting, jam and carrier sensing are handled elsewhere.
module collision_backoff_timer
    import backoff_pkg::*;
#(
    parameter int          LFSR_W    = 20,
    parameter int          RETRY_W   = 5,
    parameter int          MAX_EXP   = 10,
    parameter int          SLOT_BITS = 512,
    parameter logic [19:0] SEED      = 20'h5A5A5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               collision_i,
    input  logic [RETRY_W-1:0] retry_cnt_i,
    input  logic [1:0]         limit_sel_i,
    input  logic               bit_tick_i,
    output logic               busy_o,
    output logic               done_o
);

    logic [LFSR_W-1:0]  lfsr_q;
    logic [MAX_EXP-1:0] wait_mask;
    logic [MAX_EXP-1:0] wait_val;

    backoff_lfsr #(
        .W     (LFSR_W),
        .TAP_A (20),
        .TAP_B (17),
        .SEED  (LFSR_W'(SEED))
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .lfsr_o (lfsr_q)
    );

    backoff_exp_mask #(
        .RETRY_W (RETRY_W),
        .MAX_EXP (MAX_EXP)
    ) u_mask (
        .retry_i (retry_cnt_i),
        .limit_i (limit_e'(limit_sel_i)),
        .mask_o  (wait_mask)
    );

    // Keep only the allowed low random bits
    assign wait_val = lfsr_q[MAX_EXP-1:0] & wait_mask;

    backoff_slot_timer #(
        .SLOT_BITS (SLOT_BITS),
        .CNT_W     (MAX_EXP)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (collision_i),
        .load_i  (wait_val),
        .tick_i  (bit_tick_i),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

endmodule

// File: rtl/collision_backoff_timer_chk.sv
// Checker for the backoff timer, attached by bind. It observes only.
module collision_backoff_timer_chk #(
    parameter int LFSR_W  = 20,
    parameter int MAX_EXP = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               collision_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [LFSR_W-1:0]  lfsr_q,
    input logic [MAX_EXP-1:0] wait_val
);

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R5
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && collision_i) |=> busy_o);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R6
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && collision_i && wait_val == '0) |=> done_o);

endmodule

bind collision_backoff_timer collision_backoff_timer_chk #(
    .LFSR_W  (LFSR_W),
    .MAX_EXP (MAX_EXP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .collision_i (collision_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .lfsr_q      (lfsr_q),
    .wait_val    (wait_val)
);

// File: tb/collision_backoff_timer_tb.sv
module collision_backoff_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       collision_i = 1'b0;
    logic [4:0] retry_cnt_i = '0;
    logic [1:0] limit_sel_i = '0;
    logic       bit_tick_i = 1'b1;
    logic       busy_o;
    logic       done_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;
    bit tick_sparse = 0;

    always #4 clk = ~clk;

    collision_backoff_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .collision_i (collision_i),
        .retry_cnt_i (retry_cnt_i),
        .limit_sel_i (limit_sel_i),
        .bit_tick_i  (bit_tick_i),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    // Behavioural reference model
    int m_lfsr, m_rem, m_slot;
    bit m_busy;

    function automatic int lim_width(input int l);
        case (l)
            0: return 10;
            1: return 8;
            2: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic int eff_width(input int r, input int l);
        int k;
        k = (r < 10) ? r : 10;
        return (k < lim_width(l)) ? k : lim_width(l);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_lfsr = 'h5A5A5; m_busy = 0; m_rem = 0; m_slot = 0;
        end else begin
            if (!m_busy) begin
                if (collision_i) begin
                    m_busy = 1;
                    m_rem  = m_lfsr & ((1 << eff_width(retry_cnt_i, limit_sel_i)) - 1);
                    m_slot = 0;
                end
            end else if (m_rem == 0) begin
                m_busy = 0;
            end else if (bit_tick_i) begin
                m_slot++;
                if (m_slot == 512) begin m_slot = 0; m_rem--; end
            end
            m_lfsr = ((m_lfsr << 1) & 'hFFFFF) | (((m_lfsr >> 19) ^ (m_lfsr >> 16)) & 1);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Compare against the model on every clock (R5 done, R3 busy)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(busy_o == m_busy, "R3 busy", busy_o, m_busy);
            check(done_o == (m_busy && m_rem == 0), "R5 done", done_o, m_busy && m_rem == 0);
        end
        if (tick_sparse) bit_tick_i <= (cycles % 3 == 0);
        else             bit_tick_i <= 1'b1;
    end

    // Wait for a model random value with w in 1..wmax; with need_hi,
    // bits above the mask inside the low 10 must also be set
    task automatic pick(input int e, input int wmax, input bit need_hi);
        int w, hi;
        for (int n = 0; n < 20000; n++) begin
            @(negedge clk);
            w  = m_lfsr & ((1 << e) - 1);
            hi = m_lfsr & 'h3FF & ~((1 << e) - 1);
            if (w >= 1 && w <= wmax && (!need_hi || hi != 0)) return;
        end
        check(0, "R2 pick", 0, 1);
    endtask

    // Fire a collision now, return expected wait and measured cycles to done
    task automatic fire_and_time(output int w, output int dur);
        w = m_lfsr & ((1 << eff_width(retry_cnt_i, limit_sel_i)) - 1);
        collision_i = 1'b1;
        dur = 0;
        @(negedge clk);
        collision_i = 1'b0;
        dur = 1;
        while (!done_o && dur < 150000) begin
            @(negedge clk);
            dur++;
        end
    endtask

    task automatic run_case(input int r, input int l, input int wmax, input bit hi, input string req);
        int w, dur;
        retry_cnt_i = 5'(r);
        limit_sel_i = 2'(l);
        pick(eff_width(r, l), wmax, hi);
        fire_and_time(w, dur);
        check(w >= 1 && w <= wmax, req, w, wmax);
        check(dur == 1 + w * 512, req, dur, 1 + w * 512);
        @(negedge clk);
        check(!busy_o, "R5 busy drop", busy_o, 0);
    endtask

    initial begin
        int w, dur;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_o == 0, "R1 busy", busy_o, 0);
        check(done_o == 0, "R1 done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R1 idle", busy_o, 0);

        // R8, R6: retry 0 gives zero wait; R7: collision in the done cycle
        retry_cnt_i = 5'd0; limit_sel_i = 2'b00;
        repeat (5) @(negedge clk);
        collision_i = 1'b1;
        @(negedge clk);
        check(done_o == 1, "R6 R8 zero wait done", done_o, 1);
        @(negedge clk);
        collision_i = 1'b0;
        check(busy_o == 0, "R7 done-cycle collision ignored", busy_o, 0);
        @(negedge clk);
        check(busy_o == 0, "R7 no restart", busy_o, 0);

        // R3: retry 3, full limit
        run_case(3, 0, 7, 0, "R3 wait retry3");
        // R4: limit 2'b10 caps K=10 at 4 bits
        run_case(10, 2, 15, 1, "R4 limit narrow");
        // R4: limit 2'b11 gives one bit
        run_case(12, 3, 1, 1, "R4 limit single");
        // R4: limit 2'b01 gives 8 bits
        run_case(10, 1, 6, 1, "R4 limit medium");
        // R4: retry above 10 capped at 10 bits
        run_case(15, 0, 6, 0, "R4 retry cap");

        // R7: collision mid-wait does not change timing
        retry_cnt_i = 5'd4; limit_sel_i = 2'b00;
        pick(4, 3, 0);
        w = m_lfsr & 15;
        collision_i = 1'b1;
        @(negedge clk);
        collision_i = 1'b0;
        dur = 1;
        repeat (99) begin @(negedge clk); dur++; end
        collision_i = 1'b1;
        @(negedge clk); dur++;
        collision_i = 1'b0;
        while (!done_o && dur < 150000) begin @(negedge clk); dur++; end
        check(dur == 1 + w * 512, "R7 mid-wait collision", dur, 1 + w * 512);

        // R5: sparse ticks, compared against the model every clock
        @(negedge clk);
        tick_sparse = 1;
        retry_cnt_i = 5'd2;
        pick(2, 2, 0);
        fire_and_time(w, dur);
        check(done_o == 1, "R5 sparse tick done", done_o, 1);
        check(dur > 1 + w * 512, "R5 sparse tick longer", dur, 1 + w * 512);
        tick_sparse = 0;
        repeat (3) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule